// File: doc/BRIEF.md
# Dual-Channel Prescaled Down-Counter Timer

This block is a register-mapped timer with two independent 32-bit channels. Each channel counts down once per prescaled tick. When a tick arrives while the counter is already at zero, the counter underflows. On underflow the counter takes a fresh value from its channel's reload register and raises a sticky underflow flag. That flag, gated by an enable bit, drives the channel's interrupt line.

Software programs the block through a simple synchronous write bus with byte lane enables, and reads it back through a combinational read path. Writing an interval to both the counter and the reload register gives a periodic event. Writing zero to the reload register turns the channel into a one-shot. A channel loaded with all ones and left running serves as a free-running time base: software inverts the count to obtain a value that rises.

Top module: `dual_dn_timer`

## Requirements
- R1: After reset, each control register reads 0x00000020 (prescale select 0, interrupt enable set, flag clear). Counters, reload registers and the run register read 0, and both interrupt outputs are low.
- R2: Run register (byte offset 0x00), bit c, enables channel c. While the bit is 0 the channel's counter holds its value. Writing the run register through byte lane 0 replaces both bits at once.
- R3: Control bits [2:0] hold a field f, and the channel's counter decrements once every 4<<(2*f) clocks while it runs. Each channel has its own prescaler, which clears while the channel is stopped. So after the run bit is written at clock edge S, the first decrement lands on edge S+4<<(2*f).
- R4: A tick that finds the counter at 0 loads the counter from the reload register and sets the underflow flag, control bit 8.
- R5: With reload value N and the channel running, underflows repeat every N+1 ticks, and the counter passes through N, N-1, ..., 0.
- R6: With reload value 0, once the counter reaches zero it stays at zero, and every further tick raises the flag again.
- R7: The underflow flag is sticky. A control write through byte lane 1 with bit 8 = 0 clears it, a write with bit 8 = 1 leaves it unchanged, and an underflow in the same cycle as a clearing write leaves the flag set.
- R8: irq[c] is high exactly while channel c's flag (bit 8) and interrupt enable (bit 5) are both set.
- R9: A counter write takes effect at the next clock edge and replaces any decrement or reload due at that edge. Reads return the live counter value.
- R10: Writes update only the byte lanes whose bus_be bit is set. Control bits other than [2:0], 5 and 8 read as zero.
- R11: Each channel c has control at 0x10*(c+1), reload at +0x4 and counter at +0x8. Unmapped or misaligned addresses read 0 and ignore writes.
- R12: A channel loaded with 0xFFFFFFFF in both counter and reload, running at prescale 0, yields an inverted count equal to the number of elapsed ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 2 | Per-channel interrupt request |

## Verification
The hardest situations to reach from the ports are the two same-edge collisions: a flag-clearing write that lands on the very edge where an underflow happens, and a counter write that lands on a tick edge. Both rely on the prescaler clearing exactly when a channel is stopped. The stimulus therefore starts the channel from a stopped state with a known counter value, counts idle cycles from the run-register write, and issues the colliding bus write so that its clock edge equals the computed underflow or tick edge. A restart after a stop in the middle of a period confirms that no leftover prescaler count shortens the first period.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
    // word-address layout: word 0 is the run register, channel c owns
    // words (c+1)*REGS_PER_CH + offset
    localparam int REGS_PER_CH = 4;
    localparam int OFS_CTRL    = 0;
    localparam int OFS_CST     = 1;
    localparam int OFS_CNT     = 2;

    // control register bit positions
    localparam int CTRL_IE_BIT  = 5;
    localparam int CTRL_UNF_BIT = 8;
    localparam logic CTRL_IE_RST = 1'b1;
endpackage

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    // largest divide is 4 << (2*(2^SEL_W - 1)) = 2^(2*2^SEL_W)
    localparam int LIM_W = 2 * (1 << SEL_W);

    typedef struct packed {
        logic [LIM_W-1:0] pcnt;
    } psc_st_t;

    psc_st_t          st_d, st_q;
    logic [LIM_W-1:0] limit;

    always_comb begin
        // modulo arithmetic makes the widest divide come out as all ones
        limit = (LIM_W'(4) << {sel, 1'b0}) - LIM_W'(1);
        tick  = run && (st_q.pcnt >= limit);
        st_d  = st_q;
        if (!run || tick) begin
            st_d.pcnt = '0;
        end else begin
            st_d.pcnt = st_q.pcnt + LIM_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_PSC_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.pcnt == '0)) else $error("prescaler not cleared"); // R3
    AST_PSC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $stable(sel)) |-> (st_q.pcnt <= limit))
        else $error("prescaler past limit"); // R3
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel import dtmr_pkg::*; #(
    parameter int CNT_W = 32,
    parameter int SEL_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               wr_ctrl,
    input  logic               wr_cst,
    input  logic               wr_cnt,
    input  logic [CNT_W/8-1:0] be,
    input  logic [CNT_W-1:0]   wdata,
    output logic [SEL_W-1:0]   psc,
    output logic [CNT_W-1:0]   ctrl_rd,
    output logic [CNT_W-1:0]   cst_rd,
    output logic [CNT_W-1:0]   cnt_rd,
    output logic               irq
);
    localparam int BE_W = CNT_W / 8;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cst;
        logic [SEL_W-1:0] psc;
        logic             ie;
        logic             unf;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic   uf;
    logic   clr_req;

    function automatic logic [CNT_W-1:0] lane_merge(
        input logic [CNT_W-1:0] old_v,
        input logic [CNT_W-1:0] new_v,
        input logic [BE_W-1:0]  en
    );
        logic [CNT_W-1:0] r;
        r = old_v;
        for (int b = 0; b < BE_W; b++) begin
            if (en[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
        end
        return r;
    endfunction

    always_comb begin
        st_d    = st_q;
        uf      = tick && (st_q.cnt == '0);
        clr_req = wr_ctrl && be[CTRL_UNF_BIT/8] && !wdata[CTRL_UNF_BIT];

        if (wr_ctrl && be[0]) begin
            st_d.psc = wdata[SEL_W-1:0];
            st_d.ie  = wdata[CTRL_IE_BIT];
        end
        if (clr_req) st_d.unf = 1'b0;

        if (wr_cst) st_d.cst = lane_merge(st_q.cst, wdata, be);

        if (wr_cnt) begin
            st_d.cnt = lane_merge(st_q.cnt, wdata, be);
        end else if (uf) begin
            st_d.cnt = st_q.cst;
        end else if (tick) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end

        // a hardware underflow outranks a clearing write
        if (uf) st_d.unf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.ie  <= CTRL_IE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ctrl_rd                = '0;
        ctrl_rd[SEL_W-1:0]     = st_q.psc;
        ctrl_rd[CTRL_IE_BIT]   = st_q.ie;
        ctrl_rd[CTRL_UNF_BIT]  = st_q.unf;
        cst_rd                 = st_q.cst;
        cnt_rd                 = st_q.cnt;
        psc                    = st_q.psc;
        irq                    = st_q.unf && st_q.ie;
    end

    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.unf && !clr_req) |=> st_q.unf) else $error("flag dropped"); // R7
    AST_UF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        uf |=> st_q.unf) else $error("underflow lost flag"); // R4
    AST_UF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (uf && !wr_cnt && !wr_cst) |=> (st_q.cnt == st_q.cst))
        else $error("reload wrong"); // R4
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_cnt) |=> $stable(st_q.cnt)) else $error("counter moved"); // R2
endmodule

// File: rtl/dual_dn_timer.sv
module dual_dn_timer import dtmr_pkg::*; #(
    parameter int NCH    = 2,
    parameter int CNT_W  = 32,
    parameter int SEL_W  = 3,
    parameter int ADDR_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [CNT_W/8-1:0] bus_be,
    input  logic [CNT_W-1:0]   bus_wdata,
    output logic [CNT_W-1:0]   bus_rdata,
    output logic [NCH-1:0]     irq
);
    localparam int WORD_W = ADDR_W - 2;

    typedef struct packed {
        logic [NCH-1:0] run;
    } top_st_t;

    top_st_t           st_d, st_q;
    logic [WORD_W-1:0] word;
    logic              aligned;
    logic              wr_run;
    logic [NCH-1:0]    wr_ctrl, wr_cst, wr_cnt, tick;
    logic [CNT_W-1:0]  ctrl_rd [NCH];
    logic [CNT_W-1:0]  cst_rd  [NCH];
    logic [CNT_W-1:0]  cnt_rd  [NCH];
    logic [SEL_W-1:0]  psc     [NCH];

    assign word    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_run  = bus_wr && aligned && (word == '0) && bus_be[0];

    always_comb begin
        st_d = st_q;
        if (wr_run) st_d.run = bus_wdata[NCH-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int BASE = (c + 1) * REGS_PER_CH;

        assign wr_ctrl[c] = bus_wr && aligned && (word == WORD_W'(BASE + OFS_CTRL));
        assign wr_cst[c]  = bus_wr && aligned && (word == WORD_W'(BASE + OFS_CST));
        assign wr_cnt[c]  = bus_wr && aligned && (word == WORD_W'(BASE + OFS_CNT));

        dtmr_prescaler #(.SEL_W(SEL_W)) psc_i (
            .clk  (clk),
            .rst_n(rst_n),
            .run  (st_q.run[c]),
            .sel  (psc[c]),
            .tick (tick[c])
        );

        dtmr_channel #(.CNT_W(CNT_W), .SEL_W(SEL_W)) ch_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick[c]),
            .wr_ctrl(wr_ctrl[c]),
            .wr_cst (wr_cst[c]),
            .wr_cnt (wr_cnt[c]),
            .be     (bus_be),
            .wdata  (bus_wdata),
            .psc    (psc[c]),
            .ctrl_rd(ctrl_rd[c]),
            .cst_rd (cst_rd[c]),
            .cnt_rd (cnt_rd[c]),
            .irq    (irq[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (word == '0) bus_rdata[NCH-1:0] = st_q.run;
            for (int c = 0; c < NCH; c++) begin
                if (word == WORD_W'((c + 1) * REGS_PER_CH + OFS_CTRL)) bus_rdata = ctrl_rd[c];
                if (word == WORD_W'((c + 1) * REGS_PER_CH + OFS_CST))  bus_rdata = cst_rd[c];
                if (word == WORD_W'((c + 1) * REGS_PER_CH + OFS_CNT))  bus_rdata = cnt_rd[c];
            end
        end
    end

    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_run |=> $stable(st_q.run)) else $error("run bits moved"); // R2
    AST_TICK_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (tick & ~st_q.run) == '0) else $error("tick while stopped"); // R2
endmodule

// File: tb/dual_dn_timer_tb_top.sv
module dual_dn_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 8 ns period

    dual_dn_timer dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_be   (bus_be),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    typedef struct packed {
        logic [5:0]  a;
        logic [3:0]  be;
        logic [31:0] wd;
        logic [31:0] ex;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{6'h14, 4'hF, 32'h12345678, 32'h12345678},
        '{6'h14, 4'h1, 32'hAAAAAAAA, 32'h123456AA},
        '{6'h14, 4'hC, 32'h0000BEEF, 32'h000056AA},
        '{6'h10, 4'h3, 32'h000001FF, 32'h00000027},
        '{6'h10, 4'h2, 32'h00000000, 32'h00000027},
        '{6'h18, 4'hF, 32'hCAFEF00D, 32'hCAFEF00D},
        '{6'h28, 4'h6, 32'h11223344, 32'h00223300},
        '{6'h24, 4'h8, 32'hFF000000, 32'hFF000000},
        '{6'h20, 4'h1, 32'h00000004, 32'h00000004},
        '{6'h00, 4'hF, 32'hFFFFFFFC, 32'h00000000},
        '{6'h3C, 4'hF, 32'hDEADBEEF, 32'h00000000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        bus_addr  = a;
        bus_be    = be;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        bus_be = '0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 ctrl0", 6'h10, 32'h20);
        rd_chk("R1 ctrl1", 6'h20, 32'h20);
        rd_chk("R1 cst0",  6'h14, 32'h0);
        rd_chk("R1 cnt0",  6'h18, 32'h0);
        rd_chk("R1 cst1",  6'h24, 32'h0);
        rd_chk("R1 cnt1",  6'h28, 32'h0);
        rd_chk("R1 run",   6'h00, 32'h0);
        chk("R1 irq", {30'h0, irq}, 32'h0);

        // R10 R11 lane and map table, channels stopped
        for (int i = 0; i < NVEC; i++) begin
            wr(VECS[i].a, VECS[i].be, VECS[i].wd);
            rd_chk("R10_R11 vec", VECS[i].a, VECS[i].ex);
        end
        rd_chk("R11 misaligned", 6'h16, 32'h0);

        // R3 prescale 0 and first-period timing
        wr(6'h10, 4'h3, 32'h0);
        wr(6'h18, 4'hF, 32'd10);
        wr(6'h14, 4'hF, 32'd10);
        wr(6'h00, 4'h1, 32'h1);
        wait_n(3); rd_chk("R3 before first tick", 6'h18, 32'd10);
        wait_n(1); rd_chk("R3 first tick", 6'h18, 32'd9);
        wait_n(4); rd_chk("R3 second tick", 6'h18, 32'd8);
        // R2 freeze
        wr(6'h00, 4'h1, 32'h0);
        wait_n(40); rd_chk("R2 frozen", 6'h18, 32'd8);
        // R3 restart after stop in mid-period: full period again
        wr(6'h00, 4'h1, 32'h1);
        wait_n(3); rd_chk("R3 restart no early tick", 6'h18, 32'd8);
        wait_n(1); rd_chk("R3 restart tick", 6'h18, 32'd7);
        wr(6'h00, 4'h1, 32'h0);

        // R3 prescale 2 on channel 1, R2 channel 0 holds meanwhile
        wr(6'h20, 4'h3, 32'h2);
        wr(6'h28, 4'hF, 32'd3);
        wr(6'h00, 4'h1, 32'h2);
        wait_n(63); rd_chk("R3 div64 before", 6'h28, 32'd3);
        wait_n(1);  rd_chk("R3 div64 tick", 6'h28, 32'd2);
        rd_chk("R2 ch0 idle", 6'h18, 32'd7);
        wr(6'h00, 4'h1, 32'h0);

        // R4 R5 R8 periodic underflow
        wr(6'h10, 4'h3, 32'h20);
        wr(6'h14, 4'hF, 32'd2);
        wr(6'h18, 4'hF, 32'd0);
        wr(6'h00, 4'h1, 32'h1);
        wait_n(3); chk("R8 irq low before", {30'h0, irq}, 32'h0);
        wait_n(1);
        rd_chk("R4 reload", 6'h18, 32'd2);
        rd_chk("R4 flag set", 6'h10, 32'h120);
        chk("R8 irq high", {30'h0, irq}, 32'h1);
        wait_n(4); rd_chk("R5 count 1", 6'h18, 32'd1);
        wait_n(4); rd_chk("R5 count 0", 6'h18, 32'd0);
        wait_n(4); rd_chk("R5 reload again", 6'h18, 32'd2);
        // R7 write 1 ignored, write 0 clears
        wr(6'h10, 4'h3, 32'h120);
        rd_chk("R7 write1 ignored", 6'h10, 32'h120);
        wr(6'h10, 4'h3, 32'h020);
        rd_chk("R7 cleared", 6'h10, 32'h020);
        chk("R8 irq low after clear", {30'h0, irq}, 32'h0);
        // R7 collision: clear lands on underflow edge
        wait_n(9);
        wr(6'h10, 4'h3, 32'h020);
        rd_chk("R7 hw set wins", 6'h10, 32'h120);
        rd_chk("R4 reload at collision", 6'h18, 32'd2);
        wr(6'h10, 4'h1, 32'h000);
        chk("R8 irq masked", {30'h0, irq}, 32'h0);
        rd_chk("R8 flag kept", 6'h10, 32'h100);
        wr(6'h00, 4'h1, 32'h0);

        // R6 one-shot
        wr(6'h10, 4'h3, 32'h20);
        wr(6'h14, 4'hF, 32'd0);
        wr(6'h18, 4'hF, 32'd1);
        wr(6'h00, 4'h1, 32'h1);
        wait_n(4); rd_chk("R6 reached 0", 6'h18, 32'd0);
        rd_chk("R6 no flag yet", 6'h10, 32'h20);
        wait_n(4); rd_chk("R6 stays 0", 6'h18, 32'd0);
        rd_chk("R6 flag", 6'h10, 32'h120);
        wait_n(16); rd_chk("R6 still 0", 6'h18, 32'd0);
        wr(6'h00, 4'h1, 32'h0);

        // R9 counter write on a tick edge
        wr(6'h10, 4'h3, 32'h0);
        wr(6'h18, 4'hF, 32'd100);
        wr(6'h00, 4'h1, 32'h1);
        wait_n(3);
        wr(6'h18, 4'hF, 32'd50);
        rd_chk("R9 write wins", 6'h18, 32'd50);
        wait_n(3); rd_chk("R9 live hold", 6'h18, 32'd50);
        wait_n(1); rd_chk("R9 live dec", 6'h18, 32'd49);
        wr(6'h00, 4'h1, 32'h0);

        // R12 time base
        wr(6'h20, 4'h3, 32'h0);
        wr(6'h28, 4'hF, 32'hFFFFFFFF);
        wr(6'h24, 4'hF, 32'hFFFFFFFF);
        wr(6'h00, 4'h1, 32'h2);
        wait_n(40);
        bus_addr = 6'h28; #1; v = ~bus_rdata;
        chk("R12 stamp 10", v, 32'd10);
        wait_n(40);
        bus_addr = 6'h28; #1; v = ~bus_rdata;
        chk("R12 stamp 20", v, 32'd20);
        wr(6'h00, 4'h1, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule